// File: doc/BRIEF.md
# Dual-Source Card Clock Divider

This block chooses between two fixed reference clocks, one at 20 MHz and one at 24 MHz, and picks a 10-bit integer divider for the chosen reference. The choice gives the fastest card clock that does not exceed a requested target frequency. It then generates the divided card clock from the selected reference.

The two references arrive as single-cycle enables in the system clock domain. A target frequency in Hz is captured on a load strobe. A restoring sequential divider then works out, for each reference in turn:
- the divider, as a floor quotient forced to at least 1 and then rounded up when needed;
- the frequency that divider produces.

The faster result wins. The block raises `busy` while it computes and `done` once the new source and divider are on the outputs. The new setting reaches the card clock only at the end of a low phase, so a high pulse is never cut short.

Top module: `sdclk_divsel`

## Requirements
- R1: After reset the divider output is 61 and `src_sel` is 0, where 0 means the 20 MHz reference and 1 means the 24 MHz reference. `done` and `busy` are low, and the card clock runs at the reference rate divided by 61.
- R2: For each reference, the starting divider is the reference frequency divided by the target, rounded down. A result of 0 is raised to 1.
- R3: If the reference divided by that divider, rounded down, is still greater than the target, the divider is increased by one.
- R4: The 20 MHz reference (`src_sel`=0) is chosen only when its resulting frequency is strictly greater than the 24 MHz result. On a tie, or when the 24 MHz result is faster, `src_sel` is 1.
- R5: `div_val` is the chosen divider reduced to its low 10 bits.
- R6: A target of 0 sets `div_val` to 0 and leaves `src_sel` unchanged. Once applied, this setting holds `card_clk` low.
- R7: A load accepted while idle raises `busy` on the next cycle and clears `done`. When the result is on the outputs, `busy` falls and `done` rises in the same cycle. The two are never high together, and a load that arrives while `busy` is high is ignored.
- R8: With a divider N of 2 or more, one card clock period is N enables of the selected reference. The high phase lasts ceil(N/2) enables and the low phase floor(N/2). The count advances only when `clk_en` is high and the selected reference's enable is high; enables of the other reference have no effect.
- R9: A new divider or source takes effect only where a low phase ends, or at once while the clock is stopped. Every high and low phase is either a full phase of the old divider or a full phase of the new one.
- R10: While idle with no load, `div_val` and `src_sel` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_freq | input | 32 | Requested card clock frequency in Hz |
| tgt_load | input | 1 | Capture `tgt_freq` and start a computation |
| clk_en | input | 1 | Lets the card clock advance |
| ref_a_tick | input | 1 | Enable pulse of the 20 MHz reference |
| ref_b_tick | input | 1 | Enable pulse of the 24 MHz reference |
| src_sel | output | 1 | Chosen reference: 0 = 20 MHz, 1 = 24 MHz |
| div_val | output | 10 | Chosen divider, 0 = clock stopped |
| card_clk | output | 1 | Divided card clock |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid since the last accepted load |

## Verification
The assertions take the following for granted about the inputs:
- `tgt_freq` matters only in the cycle a load is accepted.
- The reference enables are plain single-cycle qualifiers of the system clock.
- A clock stopped by `clk_en` is resumed before any test depends on a divider change.

The stimulus holds each enable at a steady level, or drops one on purpose to show that the other reference cannot move the clock. It issues loads only while idle, except for one load placed deliberately inside a computation. It waits for each new divider to be applied at a phase boundary before it measures high and low run lengths.

// File: rtl/sdclk_divsel.sv
module sdclk_divsel #(
  parameter int FREQ_W   = 32,
  parameter int DIV_W    = 10,
  parameter int REF_A_HZ = 20_000_000,
  parameter int REF_B_HZ = 24_000_000,
  parameter int RST_DIV  = 61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] tgt_freq,
  input  logic              tgt_load,
  input  logic              clk_en,
  input  logic              ref_a_tick,
  input  logic              ref_b_tick,
  output logic              src_sel,
  output logic [DIV_W-1:0]  div_val,
  output logic              card_clk,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(FREQ_W + 1);
  localparam logic [FREQ_W-1:0] RA = FREQ_W'(REF_A_HZ);
  localparam logic [FREQ_W-1:0] RB = FREQ_W'(REF_B_HZ);
  localparam logic [DIV_W-1:0]  RD = DIV_W'(RST_DIV);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} st_t;
  typedef enum logic [1:0] {PH_FLOOR, PH_CHECK, PH_FREQ} ph_t;

  st_t st;
  ph_t ph;
  logic              ri, is_zero, done_q, res_sel, pend, pend_sel, act_sel, ck;
  logic [FREQ_W-1:0] tq, quo, dvsr;
  logic [FREQ_W:0]   rem;
  logic [CNT_W-1:0]  bcnt;
  logic [FREQ_W-1:0] dr [2];
  logic [FREQ_W-1:0] fr [2];
  logic [DIV_W-1:0]  res_div, pend_div, act_div, cnt;

  logic [FREQ_W:0]   rem_sh, rem_n;
  logic [FREQ_W-1:0] quo_n, d_base, ref_cur;
  logic              take, last, adv, pick_a, fin_go, fin_sel, ce, wrap;
  logic [DIV_W-1:0]  fin_div;
  logic [DIV_W:0]    hi, cnt_inc;

  assign rem_sh  = {rem[FREQ_W-1:0], quo[FREQ_W-1]};
  assign take    = rem_sh >= {1'b0, dvsr};
  assign rem_n   = take ? rem_sh - {1'b0, dvsr} : rem_sh;
  assign quo_n   = {quo[FREQ_W-2:0], take};
  assign last    = bcnt == CNT_W'(FREQ_W - 1);
  assign ref_cur = ri ? RB : RA;
  assign d_base  = (quo_n == '0) ? FREQ_W'(1) : quo_n;
  assign adv     = (st == S_DIV) && last &&
                   ((ph == PH_CHECK && !(quo_n > tq)) || ph == PH_FREQ);
  assign pick_a  = fr[0] > fr[1];
  assign fin_go  = st == S_FIN;
  assign fin_sel = is_zero ? res_sel : !pick_a;
  assign fin_div = is_zero ? '0 : (pick_a ? dr[0][DIV_W-1:0] : dr[1][DIV_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_FLOOR; ri <= 1'b0; is_zero <= 1'b0;
      tq <= '0; quo <= '0; dvsr <= '0; rem <= '0; bcnt <= '0;
      dr[0] <= '0; dr[1] <= '0; fr[0] <= '0; fr[1] <= '0;
      res_sel <= 1'b0; res_div <= RD; done_q <= 1'b0;
      pend_div <= RD; pend_sel <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (tgt_load) begin
          done_q  <= 1'b0;
          tq      <= tgt_freq;
          is_zero <= tgt_freq == '0;
          ri      <= 1'b0;
          ph      <= PH_FLOOR;
          quo     <= RA;
          dvsr    <= tgt_freq;
          rem     <= '0;
          bcnt    <= '0;
          st      <= (tgt_freq == '0) ? S_FIN : S_DIV;
        end
        S_DIV: begin
          rem  <= rem_n;
          quo  <= quo_n;
          bcnt <= bcnt + 1'b1;
          if (last) begin
            bcnt <= '0;
            rem  <= '0;
            case (ph)
              PH_FLOOR: begin
                dr[ri] <= d_base;
                quo    <= ref_cur;
                dvsr   <= d_base;
                ph     <= PH_CHECK;
              end
              PH_CHECK: begin
                if (quo_n > tq) begin
                  dr[ri] <= dr[ri] + 1'b1;
                  quo    <= ref_cur;
                  dvsr   <= dr[ri] + 1'b1;
                  ph     <= PH_FREQ;
                end else begin
                  fr[ri] <= quo_n;
                end
              end
              default: fr[ri] <= quo_n;
            endcase
            if (adv) begin
              if (!ri) begin
                ri   <= 1'b1;
                quo  <= RB;
                dvsr <= tq;
                ph   <= PH_FLOOR;
              end else begin
                st <= S_FIN;
              end
            end
          end
        end
        S_FIN: begin
          res_sel  <= fin_sel;
          res_div  <= fin_div;
          pend_sel <= fin_sel;
          pend_div <= fin_div;
          done_q   <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ce      = clk_en & (act_sel ? ref_b_tick : ref_a_tick);
  assign wrap    = cnt == act_div - 1'b1;
  assign hi      = ({1'b0, act_div} + 1'b1) >> 1;
  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; act_div <= RD; act_sel <= 1'b0;
      cnt <= RD - 1'b1; ck <= 1'b0;
    end else begin
      if (fin_go) pend <= 1'b1;
      if (act_div == '0) begin
        ck <= 1'b0;
        if (pend) begin
          act_div <= pend_div;
          act_sel <= pend_sel;
          cnt     <= pend_div - 1'b1;
          if (!fin_go) pend <= 1'b0;
        end else begin
          cnt <= '0;
        end
      end else if (ce) begin
        if (wrap) begin
          cnt <= '0;
          if (pend) begin
            act_div <= pend_div;
            act_sel <= pend_sel;
            ck      <= pend_div != '0;
            if (!fin_go) pend <= 1'b0;
          end else begin
            ck <= 1'b1;
          end
        end else begin
          cnt <= cnt_inc[DIV_W-1:0];
          ck  <= cnt_inc < hi;
        end
      end else if (act_div == DIV_W'(1)) begin
        ck <= 1'b0;
      end
    end
  end

  assign src_sel  = res_sel;
  assign div_val  = res_div;
  assign card_clk = ck;
  assign busy     = st != S_IDLE;
  assign done     = done_q;
endmodule

// File: rtl/sdclk_divsel_chk.sv
module sdclk_divsel_chk #(
  parameter int DIV_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tgt_load,
  input logic             clk_en,
  input logic             busy,
  input logic             done,
  input logic             card_clk,
  input logic             src_sel,
  input logic [DIV_W-1:0] div_val,
  input logic [DIV_W-1:0] act_div
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R7

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_load && !busy) |=> (busy && !done)); // R7

  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div == '0) |-> !card_clk); // R6

  AST_SWITCH_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_div) |-> (!$past(card_clk) || $past(act_div) == DIV_W'(1))); // R9

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && act_div > DIV_W'(1)) |=> $stable(card_clk)); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tgt_load) |=> ($stable(div_val) && $stable(src_sel))); // R10
endmodule

bind sdclk_divsel sdclk_divsel_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_load(tgt_load), .clk_en(clk_en),
  .busy(busy), .done(done), .card_clk(card_clk), .src_sel(src_sel),
  .div_val(div_val), .act_div(act_div)
);

// File: tb/tb_sdclk_divsel.sv
`timescale 1ns/1ps
module tb_sdclk_divsel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tgt_freq = '0;
  logic        tgt_load = 1'b0;
  logic        clk_en = 1'b1;
  logic        ref_a_tick = 1'b1;
  logic        ref_b_tick = 1'b1;
  logic        src_sel, card_clk, busy, done;
  logic [9:0]  div_val;

  int errors = 0;
  int checks = 0;
  bit last_sel = 1'b0;
  bit done_prev = 1'b0;
  logic [10:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  sdclk_divsel dut (
    .clk(clk), .rst_n(rst_n), .tgt_freq(tgt_freq), .tgt_load(tgt_load),
    .clk_en(clk_en), .ref_a_tick(ref_a_tick), .ref_b_tick(ref_b_tick),
    .src_sel(src_sel), .div_val(div_val), .card_clk(card_clk),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void calc(input longint t, output bit s, output int unsigned d);
    longint r [2];
    longint dv [2];
    longint f [2];
    r[0] = 20000000; r[1] = 24000000;
    for (int i = 0; i < 2; i++) begin
      dv[i] = r[i] / t;
      if (dv[i] == 0) dv[i] = 1;
      if (r[i] / dv[i] > t) dv[i]++;
      f[i] = r[i] / dv[i];
    end
    s = (f[0] > f[1]) ? 1'b0 : 1'b1;
    d = int'(dv[s] & 1023);
  endfunction

  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      if (exp_q.size() == 0) begin
        chk("R7", 1, 0, "unexpected done");
      end else begin
        logic [10:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(tg, src_sel, e[10], "src_sel");
        chk(tg, div_val, e[9:0], "div_val");
      end
    end
    done_prev = done;
  end

  task automatic do_load(input longint t, input string tag, input bit expect_it);
    bit s;
    int unsigned d;
    if (t == 0) begin s = last_sel; d = 0; end else calc(t, s, d);
    if (expect_it) begin
      last_sel = s;
      exp_q.push_back({s, d[9:0]});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    tgt_freq = t[31:0];
    tgt_load = 1'b1;
    @(negedge clk);
    tgt_load = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic measure(input int hi, input int lo, input string req);
    int h = 0, l = 0;
    while (card_clk) @(negedge clk);
    while (!card_clk) @(negedge clk);
    while (card_clk) begin h++; @(negedge clk); end
    while (!card_clk) begin l++; @(negedge clk); end
    chk(req, h, hi, "high run");
    chk(req, l, lo, "low run");
  endtask

  task automatic run_watch(input int cycles, input int ha, input int hb, input int la, input int lb);
    bit prev = card_clk;
    bit started = 1'b0;
    int run = 0;
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (card_clk != prev) begin
        if (started) begin
          if (prev && run != ha && run != hb) bad++;
          if (!prev && run != la && run != lb) bad++;
        end
        started = 1'b1;
        run = 1;
      end else begin
        run++;
      end
      prev = card_clk;
    end
    chk("R9", bad, 0, "truncated phases");
  endtask

  task automatic hold_check(input int cycles, input string req, input string what);
    bit v = card_clk;
    int moved = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (card_clk != v) moved++;
    end
    chk(req, moved, 0, what);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", div_val, 61, "reset div_val");
    chk("R1", src_sel, 0, "reset src_sel");
    chk("R1", done, 0, "reset done");
    chk("R1", busy, 0, "reset busy");
    measure(31, 30, "R1");

    fork
      run_watch(600, 31, 2, 30, 1);
      do_load(7000000, "R3", 1'b1);
    join
    wait_idle();
    measure(2, 1, "R8");

    do_load(400000, "R4", 1'b1);
    wait_idle();
    repeat (100) @(negedge clk);
    measure(30, 30, "R8");

    ref_b_tick = 1'b0;
    hold_check(150, "R8", "ran on unselected reference");
    ref_b_tick = 1'b1;
    clk_en = 1'b0;
    hold_check(150, "R8", "ran with clk_en low");
    clk_en = 1'b1;

    do_load(25000000, "R2", 1'b1);
    wait_idle();
    do_load(21000000, "R4", 1'b1);
    wait_idle();
    do_load(1, "R5", 1'b1);
    wait_idle();

    do_load(7000000, "R7", 1'b1);
    repeat (5) @(negedge clk);
    chk("R7", busy, 1, "busy during compute");
    do_load(400000, "R7", 1'b0);
    wait_idle();
    repeat (300) @(negedge clk);
    chk("R7", exp_q.size(), 0, "extra results");
    chk("R7", done, 1, "done held");

    do_load(0, "R6", 1'b1);
    wait_idle();
    repeat (100) @(negedge clk);
    chk("R6", card_clk, 0, "stopped clock level");
    hold_check(200, "R6", "stopped clock moved");

    do_load(400000, "R6", 1'b1);
    wait_idle();
    measure(30, 30, "R8");

    begin
      logic [9:0] d0;
      logic s0;
      d0 = div_val; s0 = src_sel;
      repeat (200) @(negedge clk);
      chk("R10", div_val, d0, "idle div_val");
      chk("R10", src_sel, s0, "idle src_sel");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule